// File: doc/BRIEF.md
# Converter Sample Averaging and Offset Correction

This block sits between an analog-to-digital converter's raw sample output and its result register. Each raw sample arrives with a one-cycle strobe and is decoded according to the current resolution and input mode: unsigned in single-ended operation, two's complement in differential operation. When averaging is on, consecutive samples are summed and only the mean of a complete set is passed on. When averaging is off, every sample passes on by itself.

The mean, or the single sample, then has a signed offset-correction value subtracted from it. The difference is clamped to the range that the active resolution and input mode can represent, and the result is presented as a 16-bit word with a one-cycle done strobe. Single-ended results are zero-filled above the data width. Differential results carry copies of the sign bit in those positions.

Resolution, mode and averaging settings are expected to stay stable while a set is being collected. The offset is applied in the cycle after a set completes.

Top module: `smp_postproc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `res_vld` is 0 and `res_data` is 0.
- R2: With averaging off, each accepted sample produces exactly one `res_vld` pulse. The pulse is low in the cycle after the clock edge that took the sample and high in the cycle after that.
- R3: `avg_sel` values 0, 1, 2 and 3 select sets of 4, 8, 16 and 32 samples. The mean is the signed sum shifted right arithmetically by 2+`avg_sel` bits, which rounds toward minus infinity.
- R4: With averaging on, no `res_vld` pulse occurs until the last sample of a set has been taken. That last sample produces exactly one pulse, with the same two-edge latency as in R2.
- R5: `res_mode` selects the data width. For single-ended/differential input, 0 selects 8/9 bits, 1 selects 12/13 bits, 2 selects 10/11 bits and 3 selects 16/16 bits. Only the low data-width bits of `raw_data` are used. They are read as unsigned when `diff_en`=0 and as two's complement when `diff_en`=1.
- R6: The result equals the mean (or single sample) minus `ofs_val`, where `ofs_val` is a two's-complement value of OFS_W bits.
- R7: A corrected value above the mode maximum is replaced by that maximum, and one below the mode minimum by that minimum. Single-ended limits are 0 and 2^N-1. Differential limits are -2^(W-1) and 2^(W-1)-1 for data width W.
- R8: In single-ended mode, every `res_data` bit at or above the data width is 0.
- R9: In differential mode, every `res_data` bit at or above the data width minus one equals the sign bit.
- R10: Dropping `avg_en` for a cycle discards any partial set. The next set with averaging on starts again from an empty sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_vld | input | 1 | Raw sample strobe |
| raw_data | input | 16 | Raw converter sample |
| res_mode | input | 2 | Resolution selector |
| diff_en | input | 1 | 1 selects differential input |
| avg_en | input | 1 | Averaging enable |
| avg_sel | input | SEL_W | Averaging set size selector |
| ofs_val | input | OFS_W | Signed offset subtracted from the result |
| res_vld | output | 1 | Result strobe |
| res_data | output | 16 | Corrected and formatted result |

## Verification
A set counter that is wrong shows at the ports within one set. The done pulse arrives after the wrong number of samples, or the mean comes out scaled by the wrong power of two. Stale accumulator contents show as a biased mean on the very next completed set, which is why a partial set is interrupted on purpose. Errors in the limits or in the decoding show on the first result that lands near a range edge. The vectors therefore sit just past both ends of every mode and input type, where an extension error flips the upper byte.

// File: rtl/smp_pkg.sv
package smp_pkg;
   localparam int RES_W = 16;
   localparam int SMP_W = RES_W + 1;

   function automatic int data_bits(input logic [1:0] mode, input logic diff);
      int n;
      case (mode)
         2'd0:    n = 8;
         2'd1:    n = 12;
         2'd2:    n = 10;
         default: n = 16;
      endcase
      if (diff && mode != 2'd3) n = n + 1;
      return n;
   endfunction

   function automatic int lim_hi(input logic [1:0] mode, input logic diff);
      int w;
      w = data_bits(mode, diff);
      return diff ? (1 << (w - 1)) - 1 : (1 << w) - 1;
   endfunction

   function automatic int lim_lo(input logic [1:0] mode, input logic diff);
      int w;
      w = data_bits(mode, diff);
      return diff ? -(1 << (w - 1)) : 0;
   endfunction
endpackage

// File: rtl/smp_decode.sv
module smp_decode #(
   parameter int RAW_W = 16,
   parameter int SMP_W = 17
) (
   input  logic [RAW_W-1:0]        raw,
   input  logic [1:0]              mode,
   input  logic                    diff,
   output logic signed [SMP_W-1:0] smp
);
   localparam int IDX_W = $clog2(RAW_W);

   logic [IDX_W:0]   width;
   logic [IDX_W-1:0] msb_idx;
   logic             fill;

   if (SMP_W <= RAW_W) begin : g_bad_w
      $error("smp_decode: SMP_W must exceed RAW_W");
   end

   always_comb begin
      width   = (IDX_W+1)'(smp_pkg::data_bits(mode, diff));
      msb_idx = IDX_W'(width - (IDX_W+1)'(1));
      fill    = diff & raw[msb_idx];
   end

   for (genvar b = 0; b < SMP_W; b++) begin : g_bit
      if (b < RAW_W) begin : g_in
         assign smp[b] = (b < int'(width)) ? raw[b] : fill;
      end else begin : g_ext
         assign smp[b] = fill;
      end
   end
endmodule

// File: rtl/smp_accum.sv
module smp_accum #(
   parameter int SMP_W = 17,
   parameter int SEL_W = 2,
   localparam int LOG_MAX = (1 << SEL_W) + 1,
   localparam int CNT_W   = LOG_MAX
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic signed [SMP_W-1:0] in_smp,
   input  logic [1:0]              in_mode,
   input  logic                    in_diff,
   input  logic                    avg_en,
   input  logic [SEL_W-1:0]        avg_sel,
   output logic                    out_vld,
   output logic signed [SMP_W-1:0] out_avg,
   output logic [1:0]              out_mode,
   output logic                    out_diff,
   output logic [CNT_W-1:0]        set_cnt
);
   localparam int ACC_W = SMP_W + LOG_MAX;

   logic signed [ACC_W-1:0] acc_q, base, sum, mean;
   logic [CNT_W-1:0]        cnt_q, last_cnt;
   logic [CNT_W:0]          set_len;
   logic [SEL_W:0]          shamt;
   logic                    set_end;

   always_comb begin
      shamt    = {1'b0, avg_sel} + (SEL_W+1)'(2);
      set_len  = (CNT_W+1)'(1) << shamt;
      last_cnt = CNT_W'(set_len - (CNT_W+1)'(1));
      set_end  = (cnt_q == last_cnt);
      base     = (cnt_q == '0) ? '0 : acc_q;
      sum      = base + ACC_W'(in_smp);
      mean     = sum >>> shamt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         cnt_q    <= '0;
         out_vld  <= 1'b0;
         out_avg  <= '0;
         out_mode <= '0;
         out_diff <= 1'b0;
      end else begin
         out_vld <= 1'b0;
         if (!avg_en) begin
            acc_q <= '0;
            cnt_q <= '0;
            if (in_vld) begin
               out_vld  <= 1'b1;
               out_avg  <= in_smp;
               out_mode <= in_mode;
               out_diff <= in_diff;
            end
         end else if (in_vld) begin
            if (set_end) begin
               out_vld  <= 1'b1;
               out_avg  <= mean[SMP_W-1:0];
               out_mode <= in_mode;
               out_diff <= in_diff;
               acc_q    <= '0;
               cnt_q    <= '0;
            end else begin
               acc_q <= sum;
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign set_cnt = cnt_q;
endmodule

// File: rtl/smp_correct.sv
module smp_correct #(
   parameter int SMP_W   = 17,
   parameter int OFS_W   = 16,
   parameter int OUT_W   = 16,
   parameter int OUT_REG = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic signed [SMP_W-1:0] in_avg,
   input  logic [1:0]              in_mode,
   input  logic                    in_diff,
   input  logic signed [OFS_W-1:0] ofs,
   output logic                    res_vld,
   output logic [OUT_W-1:0]        res_data
);
   localparam int CW = ((SMP_W > OFS_W) ? SMP_W : OFS_W) + 2;

   logic signed [CW-1:0] delta, hi, lo, clamped;
   logic [OUT_W-1:0]     fmt;

   always_comb begin
      hi    = CW'(smp_pkg::lim_hi(in_mode, in_diff));
      lo    = CW'(smp_pkg::lim_lo(in_mode, in_diff));
      delta = CW'(in_avg) - CW'(ofs);
      if (delta > hi)      clamped = hi;
      else if (delta < lo) clamped = lo;
      else                 clamped = delta;
      fmt = clamped[OUT_W-1:0];
   end

   if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_vld  <= 1'b0;
            res_data <= '0;
         end else begin
            res_vld <= in_vld;
            if (in_vld) res_data <= fmt;
         end
      end
   end else begin : g_comb
      assign res_vld  = in_vld;
      assign res_data = in_vld ? fmt : '0;
   end
endmodule

// File: rtl/smp_postproc.sv
module smp_postproc #(
   parameter int SEL_W   = 2,
   parameter int OFS_W   = 16,
   parameter int OUT_REG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_vld,
   input  logic [15:0]      raw_data,
   input  logic [1:0]       res_mode,
   input  logic             diff_en,
   input  logic             avg_en,
   input  logic [SEL_W-1:0] avg_sel,
   input  logic [OFS_W-1:0] ofs_val,
   output logic             res_vld,
   output logic [15:0]      res_data
);
   localparam int RAW_W = smp_pkg::RES_W;
   localparam int SW    = smp_pkg::SMP_W;
   localparam int CNT_W = (1 << SEL_W) + 1;

   if (SEL_W < 1 || SEL_W > 3) begin : g_chk_sel
      $error("smp_postproc: SEL_W out of range");
   end
   if (OFS_W < 2 || OFS_W > 20) begin : g_chk_ofs
      $error("smp_postproc: OFS_W out of range");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_chk_reg
      $error("smp_postproc: OUT_REG must be 0 or 1");
   end

   logic signed [SW-1:0] smp, p_avg;
   logic                 p_vld, p_diff;
   logic [1:0]           p_mode;
   logic [CNT_W-1:0]     set_cnt;

   smp_decode #(.RAW_W(RAW_W), .SMP_W(SW)) u_dec (
      .raw(raw_data), .mode(res_mode), .diff(diff_en), .smp(smp)
   );

   smp_accum #(.SMP_W(SW), .SEL_W(SEL_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .in_vld(raw_vld), .in_smp(smp),
      .in_mode(res_mode), .in_diff(diff_en), .avg_en(avg_en), .avg_sel(avg_sel),
      .out_vld(p_vld), .out_avg(p_avg), .out_mode(p_mode), .out_diff(p_diff),
      .set_cnt(set_cnt)
   );

   smp_correct #(.SMP_W(SW), .OFS_W(OFS_W), .OUT_W(RAW_W), .OUT_REG(OUT_REG)) u_cor (
      .clk(clk), .rst_n(rst_n), .in_vld(p_vld), .in_avg(p_avg),
      .in_mode(p_mode), .in_diff(p_diff), .ofs(ofs_val),
      .res_vld(res_vld), .res_data(res_data)
   );
endmodule

// File: rtl/smp_postproc_chk.sv
module smp_postproc_chk #(
   parameter int SEL_W   = 2,
   parameter int OUT_REG = 1,
   localparam int CNT_W  = (1 << SEL_W) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             raw_vld,
   input logic             avg_en,
   input logic [SEL_W-1:0] avg_sel,
   input logic [CNT_W-1:0] set_cnt,
   input logic             p_vld,
   input logic [1:0]       p_mode,
   input logic             p_diff,
   input logic             res_vld,
   input logic [15:0]      res_data
);
   localparam int LAT = (OUT_REG != 0) ? 2 : 1;

   logic [1:0] fmt_mode;
   logic       fmt_diff;

   if (OUT_REG != 0) begin : g_dly
      always_ff @(posedge clk) begin
         fmt_mode <= p_mode;
         fmt_diff <= p_diff;
      end
   end else begin : g_now
      assign fmt_mode = p_mode;
      assign fmt_diff = p_diff;
   end

   // R2, R4: a result only ever follows a sample by the fixed latency
   assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> $past(raw_vld, LAT));

   // R4: a sample that is not the last of its set produces no mean
   assert_avg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_en && raw_vld && set_cnt != CNT_W'((1 << (int'(avg_sel) + 2)) - 1))
      |=> !p_vld);

   // R10: disabled averaging empties the set
   assert_set_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !avg_en |=> set_cnt == '0);

   // R8: single-ended zero fill
   assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !fmt_diff) |-> ((res_data >> smp_pkg::data_bits(fmt_mode, 1'b0)) == 16'h0));

   // R9: differential sign extension
   assert_sign_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && fmt_diff) |->
      ((res_data >> (smp_pkg::data_bits(fmt_mode, 1'b1) - 1)) == 16'h0 ||
       (res_data >> (smp_pkg::data_bits(fmt_mode, 1'b1) - 1)) ==
       (16'hFFFF >> (smp_pkg::data_bits(fmt_mode, 1'b1) - 1))));
endmodule

bind smp_postproc smp_postproc_chk #(.SEL_W(SEL_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .raw_vld(raw_vld), .avg_en(avg_en), .avg_sel(avg_sel),
   .set_cnt(set_cnt), .p_vld(p_vld), .p_mode(p_mode), .p_diff(p_diff),
   .res_vld(res_vld), .res_data(res_data)
);

// File: tb/smp_postproc_tb.sv
`timescale 1ns/1ps
module smp_postproc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        raw_vld = 1'b0;
   logic [15:0] raw_data = '0;
   logic [1:0]  res_mode = '0;
   logic        diff_en = 1'b0;
   logic        avg_en = 1'b0;
   logic [1:0]  avg_sel = '0;
   logic [15:0] ofs_val = '0;
   logic        res_vld;
   logic [15:0] res_data;

   int n_chk = 0;
   int n_bad = 0;
   int n_res = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   smp_postproc dut_i (
      .clk(clk), .rst_n(rst_n), .raw_vld(raw_vld), .raw_data(raw_data),
      .res_mode(res_mode), .diff_en(diff_en), .avg_en(avg_en), .avg_sel(avg_sel),
      .ofs_val(ofs_val), .res_vld(res_vld), .res_data(res_data)
   );

   always @(negedge clk) if (res_vld) n_res++;

   // mode, diff, offset, raw, expected
   localparam logic [50:0] VEC [0:13] = '{
      {2'd0, 1'b0, 16'h0000, 16'h0080, 16'h0080},
      {2'd0, 1'b0, 16'h0020, 16'h0012, 16'h0000},
      {2'd0, 1'b0, 16'hFFE0, 16'h00F0, 16'h00FF},
      {2'd1, 1'b0, 16'h00BC, 16'h0ABC, 16'h0A00},
      {2'd2, 1'b0, 16'hFF00, 16'h0300, 16'h03FF},
      {2'd3, 1'b0, 16'hFFF0, 16'hFFF0, 16'hFFFF},
      {2'd0, 1'b1, 16'h0001, 16'h0100, 16'hFF00},
      {2'd0, 1'b1, 16'hFFFF, 16'h00FF, 16'h00FF},
      {2'd1, 1'b1, 16'h0002, 16'h1FFF, 16'hFFFD},
      {2'd2, 1'b1, 16'hFC00, 16'h0400, 16'h0000},
      {2'd3, 1'b1, 16'h0001, 16'h8000, 16'h8000},
      {2'd3, 1'b1, 16'h0000, 16'h7FFF, 16'h7FFF},
      {2'd1, 1'b0, 16'h0000, 16'hF123, 16'h0123},
      {2'd2, 1'b1, 16'h0100, 16'h01FF, 16'h00FF}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   // sends cnt samples; the value of sample i is v0 except the last, which is vlast
   task automatic run_set(input string req, input int cnt, input logic [15:0] v0,
                          input logic [15:0] vlast, input logic [15:0] exp);
      int n0;
      n0 = n_res;
      for (int i = 0; i < cnt; i++) begin
         raw_data = (i == cnt - 1) ? vlast : v0;
         raw_vld  = 1'b1;
         step();
      end
      raw_vld = 1'b0;
      check({req, " no early done"}, 16'(n_res - n0), 16'd0);
      check({req, " strobe idle"}, {15'd0, res_vld}, 16'd1 - 16'd1);
      step();
      check({req, " strobe"}, {15'd0, res_vld}, 16'd1);
      check({req, " value"}, res_data, exp);
      step();
      check({req, " single pulse"}, 16'(n_res - n0), 16'd1);
   endtask

   initial begin
      repeat (3) step();
      check("R1 reset valid", {15'd0, res_vld}, 16'd0);
      check("R1 reset data", res_data, 16'h0000);
      rst_n = 1'b1;
      step();
      check("R1 after release", {15'd0, res_vld}, 16'd0);

      // R2 R5 R6 R7 R8 R9: single samples with averaging off
      for (int k = 0; k < 14; k++) begin
         res_mode = VEC[k][50:49];
         diff_en  = VEC[k][48];
         ofs_val  = VEC[k][47:32];
         raw_data = VEC[k][31:16];
         raw_vld  = 1'b1;
         step();
         raw_vld = 1'b0;
         check($sformatf("R2 vec%0d latency idle", k), {15'd0, res_vld}, 16'd0);
         step();
         check($sformatf("R2 vec%0d strobe", k), {15'd0, res_vld}, 16'd1);
         check($sformatf("R7 R8 R9 vec%0d value", k), res_data, VEC[k][15:0]);
      end

      // R3 R4: each set size
      res_mode = 2'd1; diff_en = 1'b0; ofs_val = 16'h0000; avg_en = 1'b1;
      avg_sel = 2'd0;
      run_set("R3 R4 set4", 4, 16'd12, 16'd13, 16'd12);
      avg_sel = 2'd3;
      run_set("R3 R4 set32", 32, 16'd115, 16'd132, 16'd115);
      avg_sel = 2'd2; res_mode = 2'd2;
      run_set("R3 R4 set16", 16, 16'd1000, 16'd1000, 16'd1000);
      // R3: negative mean rounds down: (7*-3 + -4)/8 = -3.125 -> -4
      avg_sel = 2'd1; res_mode = 2'd3; diff_en = 1'b1;
      run_set("R3 floor set8", 8, 16'hFFFD, 16'hFFFC, 16'hFFFC);
      // R6 applied after averaging
      res_mode = 2'd1; diff_en = 1'b0; ofs_val = 16'h0010; avg_sel = 2'd0;
      run_set("R6 set4 offset", 4, 16'd100, 16'd100, 16'd84);

      // R10: partial set discarded when averaging drops
      ofs_val = 16'h0000;
      raw_data = 16'd500; raw_vld = 1'b1; step(); step(); raw_vld = 1'b0;
      avg_en = 1'b0; step();
      check("R10 no result from partial set", {15'd0, res_vld}, 16'd0);
      avg_en = 1'b1; step();
      run_set("R10 fresh set", 4, 16'd8, 16'd8, 16'd8);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule